// File: doc/BRIEF.md
# PIR Sensor Serial Settings Engine

This block loads a 48-bit configuration word into a passive-infrared motion sensor over a two-wire link. It drives the serial clock itself. It also controls the data pin through an output enable, so the pin can be driven or released. One start command runs a complete sequence:

1. Shift the word out, leaving out its dummy bit 0.
2. Send a fixed five-bit trailer.
3. Wait for a guard interval.
4. Release the data pin and clock the whole word back in.
5. Wait for a second guard interval.
6. Compare the captured word with the word that was requested.

All bit and guard timing is counted in system-clock ticks, so one parameter set adapts the block to any system clock. A deadline counter runs from the accepted start. If the sequence has not finished when the deadline expires, the sequence is aborted and a timeout is flagged.

Inside the word, the sensor decodes these fields:

| Bits | Field |
|------|-------|
| 10..17 | 8-bit detection threshold |
| 19..20 | 2-bit gain code |
| 21..23 | 3-bit filter-type code |

The engine treats the word as opaque and only guarantees the bit order on the wire.

Top module: `pir_cfg_engine`

## Requirements
- R1: During and after reset, the outputs are as follows, and the clock stays low and the data pin stays released whenever the engine is not busy:

  | Output | Value |
  |--------|-------|
  | `sclk_o` | 0 |
  | `sdata_oe_o` | 0 |
  | `busy_o` | 0 |
  | `done_o` | 0 |
  | `match_o` | 0 |
  | `timeout_o` | 0 |

- R2: On an accepted start, the word is latched and its bits 1..47 are sent least significant first with `sdata_oe_o` high. Each clock half lasts HALF_TICKS cycles. The first rising edge of `sclk_o` comes HALF_TICKS cycles after the start edge. Data changes only while the clock is low.
- R3: Directly after bit 47, five trailer bits are sent with the same clocking, in wire order 0, 1, 1, 0, 1. The parameter value is 5'b10110, sent LSB first.
- R4: After the trailer, and again after the read phase, the engine waits GUARD_TICKS cycles. During these waits the clock is low and the data pin is released.
- R5: In the read phase, the data pin stays released while 48 clock periods are generated. Each bit is taken at the last cycle of the clock-high half, least significant bit first. The bit captured first (position 0) is forced to zero whatever the sensor drives.
- R6: At completion, `match_o` is 1 exactly when all 48 captured bits equal the latched word. A word with bit 0 set can therefore never match.
- R7: With no deadline expiry, `done_o` rises 200*HALF_TICKS + 2*GUARD_TICKS cycles after the start edge.
- R8: If DEADLINE_TICKS cycles pass from the start edge before completion, the engine aborts at once:

  | Output | Value |
  |--------|-------|
  | `done_o` | 1 |
  | `timeout_o` | 1 |
  | `match_o` | 0 |
  | `sclk_o` | low |
  | `sdata_oe_o` | released |

  A completion on the same edge as the expiry counts as success.
- R9: A start request while busy is ignored: the latched word, the bits sent and the completion time are unchanged.
- R10: `done_o`, `match_o` and `timeout_o` hold their values until the next accepted start, which clears all three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted when idle |
| settings_i | input | 48 | Configuration word to load |
| sdata_i | input | 1 | Data pin level from the sensor |
| sclk_o | output | 1 | Serial clock to the sensor |
| sdata_o | output | 1 | Data value driven when enabled |
| sdata_oe_o | output | 1 | Data pin drive enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence ended, held until next start |
| match_o | output | 1 | Read-back equalled the requested word |
| timeout_o | output | 1 | Deadline expired before completion |

## Verification
The in-RTL assertions check the following on every cycle:
- the link is quiet whenever the engine is idle;
- the data pin is driven only while busy;
- the data does not move while the clock is high;
- the latched word stays constant during a run;
- the result flags are held while done;
- a timeout always comes with done and no match.

The bench's scenarios are needed for the rest:
- the exact bit order on the wire, including the trailer and the skipped bit 0;
- the position of the first clock edge and the guard interval;
- the total completion time;
- the forced-zero dummy bit, the mismatch cases, and the deadline boundary one cycle either side.

// File: rtl/pir_cfg_pkg.sv
package pir_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_TX_GUARD,
    ST_RX,
    ST_RX_GUARD
  } seq_st_e;
endpackage

// File: rtl/pir_tick_timer.sv
// Free-running interval counter: expire_o pulses on the last cycle of each
// interval of limit_i cycles, then the count restarts.
module pir_tick_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr_i || expire_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + CW'(1);
  end

  // R2
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/pir_deadline.sv
// Counts cycles of a running sequence; hit_o is high during the cycle whose
// closing edge is the LIMIT-th edge after arming.
module pir_deadline #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || arm_i)          cnt_q <= '0;
    else if (run_i && !hit_o)  cnt_q <= cnt_q + CW'(1);
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/pir_cfg_engine.sv
module pir_cfg_engine
  import pir_cfg_pkg::*;
#(
  parameter int          WORD_W         = 48,
  parameter int          HALF_TICKS     = 62500,
  parameter int          GUARD_TICKS    = 3750000,
  parameter int          DEADLINE_TICKS = 175000000,
  parameter int          TRAIL_W        = 5,
  parameter logic [4:0]  TRAIL_SEQ      = 5'b10110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] settings_i,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              match_o,
  output logic              timeout_o
);
  localparam int TX_W = WORD_W - 1 + TRAIL_W;
  localparam int MAXT = (GUARD_TICKS > HALF_TICKS) ? GUARD_TICKS : HALF_TICKS;
  localparam int TCW  = $clog2(MAXT + 1);
  localparam int BCW  = $clog2(TX_W + 1);

  seq_st_e           st_q;
  logic              phase_q;
  logic [BCW-1:0]    bit_q;
  logic [TX_W-1:0]   tx_sr;
  logic [WORD_W-1:0] rx_sr;
  logic [WORD_W-1:0] want_q;
  logic              sdi_s1, sdi_s2;
  logic [TCW-1:0]    lim;
  logic              tmr_exp, dl_hit, accept, finish;

  assign lim    = (st_q == ST_TX_GUARD || st_q == ST_RX_GUARD) ?
                  TCW'(GUARD_TICKS) : TCW'(HALF_TICKS);
  assign accept = (st_q == ST_IDLE) && start_i;
  assign finish = (st_q == ST_RX_GUARD) && tmr_exp;

  pir_tick_timer #(.CW(TCW)) u_tmr (
    .clk(clk), .rst(rst), .clr_i(st_q == ST_IDLE),
    .limit_i(lim), .expire_o(tmr_exp)
  );

  pir_deadline #(.LIMIT(DEADLINE_TICKS)) u_dl (
    .clk(clk), .rst(rst), .arm_i(accept), .run_i(busy_o), .hit_o(dl_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdi_s1 <= 1'b0;
      sdi_s2 <= 1'b0;
    end else begin
      sdi_s1 <= sdata_i;
      sdi_s2 <= sdi_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      phase_q    <= 1'b0;
      bit_q      <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      want_q     <= '0;
      sclk_o     <= 1'b0;
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      match_o    <= 1'b0;
      timeout_o  <= 1'b0;
    end else if (busy_o && dl_hit && !finish) begin
      st_q       <= ST_IDLE;
      sclk_o     <= 1'b0;
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b1;
      match_o    <= 1'b0;
      timeout_o  <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          want_q     <= settings_i;
          tx_sr      <= {TRAIL_SEQ, settings_i[WORD_W-1:1]};
          sdata_o    <= settings_i[1];
          sdata_oe_o <= 1'b1;
          sclk_o     <= 1'b0;
          phase_q    <= 1'b0;
          bit_q      <= '0;
          busy_o     <= 1'b1;
          done_o     <= 1'b0;
          match_o    <= 1'b0;
          timeout_o  <= 1'b0;
          st_q       <= ST_TX;
        end
        ST_TX: if (tmr_exp) begin
          if (!phase_q) begin
            sclk_o  <= 1'b1;
            phase_q <= 1'b1;
          end else begin
            sclk_o  <= 1'b0;
            phase_q <= 1'b0;
            if (bit_q == BCW'(TX_W - 1)) begin
              st_q       <= ST_TX_GUARD;
              sdata_oe_o <= 1'b0;
              sdata_o    <= 1'b0;
            end else begin
              bit_q   <= bit_q + BCW'(1);
              tx_sr   <= tx_sr >> 1;
              sdata_o <= tx_sr[1];
            end
          end
        end
        ST_TX_GUARD: if (tmr_exp) begin
          st_q    <= ST_RX;
          bit_q   <= '0;
          phase_q <= 1'b0;
        end
        ST_RX: if (tmr_exp) begin
          if (!phase_q) begin
            sclk_o  <= 1'b1;
            phase_q <= 1'b1;
          end else begin
            sclk_o  <= 1'b0;
            phase_q <= 1'b0;
            rx_sr   <= {sdi_s2, rx_sr[WORD_W-1:1]};
            if (bit_q == BCW'(WORD_W - 1)) st_q <= ST_RX_GUARD;
            else                           bit_q <= bit_q + BCW'(1);
          end
        end
        ST_RX_GUARD: if (tmr_exp) begin
          st_q    <= ST_IDLE;
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
          match_o <= ({rx_sr[WORD_W-1:1], 1'b0} == want_q);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!sclk_o && !sdata_oe_o));
  // R2
  drive_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    sdata_oe_o |-> busy_o);
  // R2
  data_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && sdata_oe_o) |=> (!sclk_o || $stable(sdata_o)));
  // R9
  word_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(want_q));
  // R10
  flags_held_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(match_o) && $stable(timeout_o)));
  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (!done_o && !match_o && !timeout_o));
  // R8
  tmo_shape_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (done_o && !match_o && !busy_o));
endmodule

// File: tb/pir_cfg_engine_tb.sv
module pir_cfg_engine_tb_top;
  localparam int H = 4;
  localparam int G = 20;
  localparam int T = 200 * H + 2 * G;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start, sdata_i;
  logic [47:0] settings;
  logic sclk_o, sdata_o, sdata_oe_o, busy_o, done_o, match_o, timeout_o;

  logic        t_start;
  logic t_sclk, t_sd, t_oe, t_busy, t_done, t_match, t_tmo;

  pir_cfg_engine #(.HALF_TICKS(H), .GUARD_TICKS(G), .DEADLINE_TICKS(T)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .settings_i(settings),
    .sdata_i(sdata_i), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .sdata_oe_o(sdata_oe_o), .busy_o(busy_o), .done_o(done_o),
    .match_o(match_o), .timeout_o(timeout_o));

  pir_cfg_engine #(.HALF_TICKS(H), .GUARD_TICKS(G), .DEADLINE_TICKS(T - 1)) dut_to (
    .clk(clk), .rst(rst), .start_i(t_start), .settings_i(48'h0000_0012_3456),
    .sdata_i(1'b0), .sclk_o(t_sclk), .sdata_o(t_sd),
    .sdata_oe_o(t_oe), .busy_o(t_busy), .done_o(t_done),
    .match_o(t_match), .timeout_o(t_tmo));

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sensor model
  logic [51:0] cap;
  logic [47:0] stored;
  int  wr_n = 0, rd_n = 0, flip_idx = -1;
  bit  dummy_val = 1'b1;
  initial sdata_i = 1'b0;
  always @(posedge sclk_o) begin
    if (sdata_oe_o) begin
      cap[wr_n] = sdata_o;
      wr_n++;
      if (wr_n == 52) stored = {cap[46:0], 1'b0};
    end else begin
      if (rd_n == 0) sdata_i = dummy_val;
      else           sdata_i = stored[rd_n] ^ (rd_n == flip_idx);
      rd_n++;
    end
  end

  // Scoreboard
  typedef struct {
    logic [47:0] word;
    bit          match;
    int          c0;
  } exp_t;
  exp_t q[$];

  task automatic launch(input logic [47:0] w, input bit exp_match,
                        input int flip, input bit dmy);
    exp_t e;
    flip_idx  = flip;
    dummy_val = dmy;
    wr_n = 0;
    rd_n = 0;
    @(negedge clk);
    start = 1'b1;
    settings = w;
    @(negedge clk);
    start = 1'b0;
    e.word = w;
    e.match = exp_match;
    e.c0 = cyc;
    q.push_back(e);
  endtask

  bit done_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && done_o && !done_prev && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(cap[46:0] == e.word[47:1], "R2", "bits 1..47 on wire", cap[46:0], e.word[47:1]);
      chk(cap[51:47] == 5'b10110, "R3", "trailer", cap[51:47], 5'b10110);
      chk(wr_n == 52 && rd_n == 48, "R5", "clock periods w/r", wr_n * 100 + rd_n, 5248);
      chk(match_o == e.match, "R6", "match", match_o, e.match);
      chk(timeout_o == 1'b0, "R8", "no timeout at deadline boundary", timeout_o, 0);
      chk(cyc - e.c0 == T, "R7", "completion cycles", cyc - e.c0, T);
    end
    done_prev = done_o;
  end

  task automatic wait_done;
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    chk(0, "WD", "watchdog expired", wd, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] w;
    start = 1'b0;
    t_start = 1'b0;
    settings = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!sclk_o && !sdata_oe_o, "R1", "link quiet in reset", {sclk_o, sdata_oe_o}, 0);
    chk(!busy_o && !done_o && !match_o && !timeout_o, "R1", "flags in reset",
        {busy_o, done_o, match_o, timeout_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sclk_o && !busy_o, "R1", "idle after reset", {sclk_o, busy_o}, 0);

    // Run 1: timing of first edge, guard and read release
    launch(48'hA5C3_1E0F_7B6E, 1'b1, -1, 1'b1);
    for (int i = 1; i < H; i++) begin
      @(negedge clk);
      chk(sclk_o == 1'b0, "R2", "clock low before first edge", sclk_o, 0);
    end
    @(negedge clk);
    chk(sclk_o == 1'b1 && sdata_oe_o, "R2", "first rising edge", sclk_o, 1);
    repeat (104 * H - H) @(negedge clk);
    chk(!sdata_oe_o && !sclk_o, "R4", "released after trailer", {sdata_oe_o, sclk_o}, 0);
    repeat (G) @(negedge clk);
    chk(!sclk_o && rd_n == 0, "R4", "clock low through guard", {sclk_o, 8'(rd_n)}, 0);
    repeat (H) @(negedge clk);
    chk(sclk_o && !sdata_oe_o, "R5", "first read edge, pin released",
        {sclk_o, sdata_oe_o}, 2'b10);
    wait_done();

    // R10 flags held
    repeat (50) @(negedge clk);
    chk(done_o && match_o && !busy_o, "R10", "flags held", {done_o, match_o, busy_o}, 3'b110);

    // Run 2: field-built word; start while busy ignored (R9)
    w = 48'h5A5A5A_000000;
    w[17:10] = 8'd56;
    w[20:19] = 2'b11;
    w[23:21] = 3'b111;
    launch(w, 1'b1, -1, 1'b1);
    chk(!done_o && busy_o, "R10", "new start clears done", {done_o, busy_o}, 1);
    repeat (100) @(negedge clk);
    start = 1'b1;
    settings = 48'hFFFF_0000_FFFE;
    @(negedge clk);
    start = 1'b0;
    wait_done();   // R9: monitor checks the original word and completion time

    // Run 3: corrupted read-back -> mismatch (R6)
    launch(48'h1234_5678_9ABC, 1'b0, 30, 1'b0);
    wait_done();

    // Run 4: bit 0 set can never match (R5/R6)
    launch(48'h0F0F_F0F0_0001, 1'b0, -1, 1'b0);
    wait_done();

    // Run 5: all ones above bit 0, dummy driven 1 is forced to zero (R5)
    launch(48'hFFFF_FFFF_FFFE, 1'b1, -1, 1'b1);
    wait_done();
    launch(48'h0, 1'b1, -1, 1'b1);
    wait_done();

    // R8 timeout one cycle before completion
    begin
      int c0;
      @(negedge clk);
      t_start = 1'b1;
      @(negedge clk);
      t_start = 1'b0;
      c0 = cyc;
      repeat (T - 2) @(negedge clk);
      chk(t_busy && !t_done, "R8", "still running before deadline", {t_busy, t_done}, 2'b10);
      @(negedge clk);
      chk(t_done && t_tmo && !t_match && !t_busy, "R8", "timeout abort",
          {t_done, t_tmo, t_match, t_busy}, 4'b1100);
      chk(!t_sclk && !t_oe, "R8", "link quiet after abort", {t_sclk, t_oe}, 0);
      chk(cyc - c0 == T - 1, "R8", "abort cycle", cyc - c0, T - 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule